// File: doc/BRIEF.md
# Multi-Channel Reloadable Down-Counting Timer

This block holds several independent timer channels behind a single-cycle register bus. Every channel owns a 32-bit down counter, a 32-bit reload value and a 16-bit control word. One shared start register holds a run bit for each channel. A running channel decrements once per prescaled tick of the peripheral clock. When a tick finds the counter at zero, that tick is an underflow: the counter takes the reload value, the channel sets its underflow flag, and it can hold a level interrupt high.

A reload value of zero makes the channel a one-shot. After its first underflow the channel stops counting and raises no further events until software stops it and starts it again. Software gets an up-counting time base by inverting the counter value it reads. To reprogram a channel, software stops it, writes the control word, the reload value and the counter, and then sets the run bit again.

Each channel is a three-state machine:
- `CH_STOP`: the channel is halted.
- `CH_COUNT`: the channel is counting.
- `CH_EXPIRED`: a one-shot has fired and the channel is parked.

The transitions are:
- go (`CH_STOP` to `CH_COUNT`): the run bit is set.
- halt (`CH_COUNT` or `CH_EXPIRED` to `CH_STOP`): the run bit is cleared.
- fire-once (`CH_COUNT` to `CH_EXPIRED`): an underflow occurs while the reload value is zero.

Top module: `rtimer`

## Requirements
- R1: After reset, the start register and every control word read as zero. Every reload register and counter reads 0xFFFFFFFF, all channels are stopped and `irq` is all zero.
- R2: The start register is at address 0x00 and bit n runs channel n. Bits that have no channel read as zero. While a channel's run bit is clear, its counter does not change unless software writes it.
- R3: Channel n has its registers at base 0x10*(n+1): reload at +0x0, counter at +0x4 and control at +0x8. A write to one register leaves all the others unchanged.
- R4: Control bits 2:0 choose the count divisor D: 000 gives 4, 001 gives 16, 010 gives 64 and 011 gives 256. Any other code gives 4. Take a stopped channel holding counter value N and write its run bit at clock edge E. Its first underflow then occurs at edge E + 1 + D*(N+1).
- R5: An underflow loads the counter from the reload register and sets control bit 8, the underflow flag. With a nonzero reload value, underflows keep repeating.
- R6: Writing control bit 8 as 0 clears the flag, and writing it as 1 leaves the flag unchanged. If an underflow coincides with a clearing write, the flag ends up set.
- R7: `irq[n]` is high exactly when channel n has its flag set and its control bit 5, interrupt enable, set.
- R8: With a reload value of zero, the channel sets its flag once at underflow, then holds the counter at 0 and sets the flag no more while it stays started.
- R9: A write to the counter takes effect at the next clock edge and overrides any count step in that same cycle.
- R10: A control read returns the prescaler code in bits 2:0, the interrupt enable in bit 5 and the flag in bit 8. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | AW | Byte address of the register |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Combinational read data for `bus_addr` |
| irq | output | NCH | Level interrupt, one per channel |

## Verification
The assertions assume the following about the bus:
- every write lasts exactly one cycle;
- addresses outside the decoded map are never written;
- software stops a channel before it reloads a one-shot.

The stimulus drives one bus access at a time, clear of the active edge, and stops a channel before every reprogramming. The cycle-exact underflow checks use only channels whose flag is clear and whose counter is loaded while they are stopped. This keeps the start-to-underflow latency of R4 well defined.

// File: rtl/rtimer_pkg.sv
`timescale 1ns/1ps
package rtimer_pkg;
    localparam int CTRL_W = 16;
    localparam int PSC_W  = 3;
    localparam int PCNT_W = 8;
    localparam int BIT_IE = 5;
    localparam int BIT_UF = 8;

    typedef enum logic [1:0] {
        CH_STOP,
        CH_COUNT,
        CH_EXPIRED
    } ch_state_e;

    // last prescaler count before a tick, from the divisor code
    function automatic logic [PCNT_W-1:0] psc_last(input logic [PSC_W-1:0] code);
        case (code)
            3'd1:    return 8'd15;
            3'd2:    return 8'd63;
            3'd3:    return 8'd255;
            default: return 8'd3;
        endcase
    endfunction
endpackage

// File: rtl/rtimer_prescaler.sv
`timescale 1ns/1ps
module rtimer_prescaler
    import rtimer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [PCNT_W-1:0] pcnt;

    assign tick = en && (pcnt >= psc_last(psc));

    always_ff @(posedge clk) begin
        if (!rst_n || !en || tick) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/rtimer_channel.sv
`timescale 1ns/1ps
module rtimer_channel
    import rtimer_pkg::*;
#(
    parameter int W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              wr_reload,
    input  logic              wr_count,
    input  logic              wr_ctrl,
    input  logic [W-1:0]      wdata,
    output logic [W-1:0]      reload_o,
    output logic [W-1:0]      count_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              irq_o
);
    ch_state_e        state, state_n;
    logic [W-1:0]     reload_q, count_q;
    logic [PSC_W-1:0] psc_q;
    logic             ie_q, flag_q;
    logic             count_en, tick, uf;

    assign count_en = run && (state == CH_COUNT);
    assign uf       = tick && (count_q == '0);

    rtimer_prescaler u_psc (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (count_en),
        .psc  (psc_q),
        .tick (tick)
    );

    // next-state decision
    always_comb begin
        state_n = state;
        unique case (state)
            CH_STOP:    if (run) state_n = CH_COUNT;
            CH_COUNT: begin
                if (!run)                          state_n = CH_STOP;
                else if (uf && reload_q == '0)     state_n = CH_EXPIRED;
            end
            CH_EXPIRED: if (!run) state_n = CH_STOP;
            default:    state_n = CH_STOP;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_STOP;
        else        state <= state_n;
    end

    // datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload_q <= '1;
            count_q  <= '1;
            psc_q    <= '0;
            ie_q     <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            if (wr_reload) reload_q <= wdata;
            if (wr_count)  count_q  <= wdata;
            else if (tick) count_q  <= (count_q == '0) ? reload_q : count_q - 1'b1;
            if (wr_ctrl) begin
                ie_q  <= wdata[BIT_IE];
                psc_q <= wdata[PSC_W-1:0];
            end
            flag_q <= (flag_q & ~(wr_ctrl & ~wdata[BIT_UF])) | uf;
        end
    end

    assign reload_o = reload_q;
    assign count_o  = count_q;
    always_comb begin
        ctrl_o               = '0;
        ctrl_o[PSC_W-1:0]    = psc_q;
        ctrl_o[BIT_IE]       = ie_q;
        ctrl_o[BIT_UF]       = flag_q;
    end
    assign irq_o = flag_q & ie_q;
endmodule

// File: rtl/rtimer.sv
`timescale 1ns/1ps
module rtimer
    import rtimer_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 8,
    parameter int DW  = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_addr,
    input  logic [DW-1:0]  bus_wdata,
    output logic [DW-1:0]  bus_rdata,
    output logic [NCH-1:0] irq
);
    localparam int CH_AW = AW - 4;

    logic [NCH-1:0]              start_q;
    logic [NCH-1:0]              ch_hit;
    logic [NCH-1:0]              wr_cnt_v;
    logic [NCH-1:0][DW-1:0]      rld_v, cnt_v;
    logic [NCH-1:0][CTRL_W-1:0]  ctrl_v;

    always_ff @(posedge clk) begin
        if (!rst_n)                         start_q <= '0;
        else if (bus_we && bus_addr == '0)  start_q <= bus_wdata[NCH-1:0];
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign ch_hit[i]   = (bus_addr[AW-1:4] == CH_AW'(i + 1));
        assign wr_cnt_v[i] = bus_we && ch_hit[i] && bus_addr[3:0] == 4'h4;

        rtimer_channel #(.W(DW)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (start_q[i]),
            .wr_reload(bus_we && ch_hit[i] && bus_addr[3:0] == 4'h0),
            .wr_count (wr_cnt_v[i]),
            .wr_ctrl  (bus_we && ch_hit[i] && bus_addr[3:0] == 4'h8),
            .wdata    (bus_wdata),
            .reload_o (rld_v[i]),
            .count_o  (cnt_v[i]),
            .ctrl_o   (ctrl_v[i]),
            .irq_o    (irq[i])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == '0) bus_rdata[NCH-1:0] = start_q;
        for (int i = 0; i < NCH; i++) begin
            if (ch_hit[i]) begin
                case (bus_addr[3:0])
                    4'h0:    bus_rdata = rld_v[i];
                    4'h4:    bus_rdata = cnt_v[i];
                    4'h8:    bus_rdata = {{(DW-CTRL_W){1'b0}}, ctrl_v[i]};
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/rtimer_chk.sv
`timescale 1ns/1ps
module rtimer_chk #(
    parameter int NCH = 3,
    parameter int DW  = 32
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NCH-1:0]         start_q,
    input logic [NCH-1:0]         wr_cnt_v,
    input logic [NCH-1:0][DW-1:0] cnt_v,
    input logic [NCH-1:0][DW-1:0] rld_v,
    input logic [NCH-1:0][15:0]   ctrl_v,
    input logic [NCH-1:0]         irq
);
    for (genvar i = 0; i < NCH; i++) begin : g_a
        AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
            (!start_q[i] && !wr_cnt_v[i]) |=> (cnt_v[i] == $past(cnt_v[i]))); // R2
        AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_cnt_v[i] |=> (cnt_v[i] == $past(cnt_v[i]) || cnt_v[i] == $past(cnt_v[i]) - 1
                || ($past(cnt_v[i]) == '0 && cnt_v[i] == $past(rld_v[i])))); // R4
        AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(ctrl_v[i][8]) |-> ($past(cnt_v[i]) == '0 && $past(start_q[i]))); // R5
        AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
            irq[i] |-> (ctrl_v[i][8] && ctrl_v[i][5])); // R7
    end
endmodule

bind rtimer rtimer_chk #(.NCH(NCH), .DW(DW)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_q (start_q),
    .wr_cnt_v(wr_cnt_v),
    .cnt_v   (cnt_v),
    .rld_v   (rld_v),
    .ctrl_v  (ctrl_v),
    .irq     (irq)
);

// File: tb/rtimer_tb_top.sv
`timescale 1ns/1ps
module rtimer_tb_top;
    localparam int NCH = 3;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NCH-1:0] irq;

    int nchk = 0, nerr = 0;
    bit done = 0, rd_pend = 0;

    typedef struct { logic [31:0] exp; string tag; } sb_item_t;
    sb_item_t sb_q[$];

    always #2.5 clk = ~clk;

    rtimer #(.NCH(NCH)) dut_i (.*);

    function automatic logic [7:0] ra(input int ch, input int off);
        return 8'((ch + 1) * 16 + off);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected reads and compares
    always @(negedge clk) begin
        if (rd_pend && sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            chk(bus_rdata == it.exp, it.tag, bus_rdata, it.exp);
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #1;
        bus_addr = a;
        sb_q.push_back('{e, t});
        rd_pend = 1'b1;
        @(negedge clk); #1;
        rd_pend = 1'b0;
    endtask

    task automatic wait_irq(input int ch, input int exp, input string t);
        int n = 0;
        while (n < 400 && !irq[ch]) begin
            @(posedge clk); #1;
            n++;
        end
        chk(n == exp, t, 32'(n), 32'(exp));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        rd_chk(8'h00, 32'h0, "R1 start reg");
        rd_chk(ra(0, 0), 32'hFFFF_FFFF, "R1 reload ch0");
        rd_chk(ra(1, 4), 32'hFFFF_FFFF, "R1 counter ch1");
        rd_chk(ra(2, 8), 32'h0, "R1 ctrl ch2");
        chk(irq == '0, "R1 irq", 32'(irq), 32'h0);
        // R9 / R3 writes while stopped
        wr(ra(0, 4), 32'h55);
        rd_chk(ra(0, 4), 32'h55, "R9 counter write");
        wr(ra(1, 0), 32'h1234);
        rd_chk(ra(1, 0), 32'h1234, "R3 reload ch1");
        rd_chk(ra(1, 4), 32'hFFFF_FFFF, "R3 counter ch1 untouched");
        // R2 start reg width
        wr(8'h00, 32'hFF);
        rd_chk(8'h00, 32'h7, "R2 start readback");
        wr(8'h00, 32'h0);
        // R10 control format
        wr(ra(2, 8), 32'hFFFF);
        rd_chk(ra(2, 8), 32'h0027, "R10 ctrl readback");
        // R4/R5/R7 periodic ch0
        wr(ra(0, 0), 32'd3);
        wr(ra(0, 8), 32'h0020);
        wr(ra(0, 4), 32'd3);
        wr(8'h00, 32'h1);
        wait_irq(0, 17, "R4 div4 latency");
        rd_chk(ra(0, 4), 32'd3, "R5 reload on underflow");
        rd_chk(ra(0, 8), 32'h0120, "R5 flag set");
        wr(8'h00, 32'h0);
        // R6 flag write semantics
        wr(ra(0, 8), 32'h0120);
        rd_chk(ra(0, 8), 32'h0120, "R6 write1 keeps flag");
        wr(ra(0, 8), 32'h0000);
        rd_chk(ra(0, 8), 32'h0000, "R6 write0 clears flag");
        chk(irq[0] == 1'b0, "R7 irq low after clear", 32'(irq[0]), 32'h0);
        wr(ra(0, 8), 32'h0020);
        wr(8'h00, 32'h1);
        repeat (100) @(posedge clk);
        rd_chk(ra(0, 8), 32'h0120, "R5 periodic repeat");
        wr(8'h00, 32'h0);
        wr(ra(0, 8), 32'h0100);
        #1 chk(irq[0] == 1'b0, "R7 ie off masks irq", 32'(irq[0]), 32'h0);
        rd_chk(ra(0, 8), 32'h0100, "R7 flag kept with ie off");
        // R2 freeze on stop
        wr(ra(1, 4), 32'd1000);
        wr(8'h00, 32'h2);
        repeat (40) @(posedge clk);
        wr(8'h00, 32'h0);
        rd_chk(ra(1, 4), 32'd990, "R2 count at stop");
        repeat (30) @(posedge clk);
        rd_chk(ra(1, 4), 32'd990, "R2 frozen");
        // R4 divide by 16
        wr(ra(1, 0), 32'hFFFF_FFFF);
        wr(ra(1, 8), 32'h0021);
        wr(ra(1, 4), 32'd1);
        wr(8'h00, 32'h2);
        wait_irq(1, 33, "R4 div16 latency");
        // R4 unused code behaves as /4
        wr(ra(2, 8), 32'h0027);
        wr(ra(2, 4), 32'd1);
        wr(8'h00, 32'h6);
        wait_irq(2, 9, "R4 code7 as div4");
        wr(8'h00, 32'h0);
        // R8 one-shot
        wr(ra(0, 8), 32'h0020);
        wr(ra(0, 0), 32'd0);
        wr(ra(0, 4), 32'd2);
        wr(8'h00, 32'h1);
        wait_irq(0, 13, "R8 one-shot latency");
        rd_chk(ra(0, 4), 32'd0, "R8 counter after fire");
        wr(ra(0, 8), 32'h0020);
        repeat (60) @(posedge clk);
        rd_chk(ra(0, 8), 32'h0020, "R8 no second event");
        chk(irq[0] == 1'b0, "R8 irq stays low", 32'(irq[0]), 32'h0);
        rd_chk(ra(0, 4), 32'd0, "R8 counter held");
        repeat (3) @(posedge clk);
        finish_run();
    end
endmodule